// File: doc/BRIEF.md
# Peripheral Clock Prescaler with Wait Gating

This block turns two free-running tick streams, one per period of the main clock and one per period of the sub-clock, into a set of single-cycle clock enables for peripherals. Everything runs in the fast system clock domain `clk`. The main-clock side gives three things:

- a full-rate enable and two slower enables at one eighth and one thirty-second of the main rate;
- an A/D enable at the main rate;
- a CAN-controller enable whose ratio (1, 2, 4, 8 or 16) comes from a select input.

The sub-clock side gives a timer enable at one thirty-second of the sub rate and an undivided watchdog enable.

A wait gate stops the main-derived divided enables. The gate closes when a WAIT strobe arrives while the peripheral-stop bit is 1, and it opens on the wake input. While the gate is closed, or while the main clock is flagged as not running, the main dividers freeze their counts. When the enables resume, they continue the period they had started, so no short period appears. The sub-clock enables ignore the gate.

Top module: `periph_clk_prescaler`

## Requirements
- R1: Each main tick accepted (main_run is 1 and the gate is open) gives one `en_f1` pulse, one clock cycle after the tick is sampled.
- R2: `en_f8` pulses on every 8th accepted main tick and `en_f32` on every 32nd, counted from reset.
- R3: `en_adc` pulses once for each main tick sampled while main_run is 1, whether the wait gate is open or closed.
- R4: `can_sel` picks the CAN ratio: 0, 1, 2, 3 and 4 give 1, 2, 4, 8 and 16, and values 5 to 7 give 16. After reset the ratio register holds 1, so the first accepted tick gives an `en_can` pulse and loads the selected ratio.
- R5: A change of `can_sel` is taken up only at the CAN divider's next terminal count. The period already under way finishes at the old ratio.
- R6: A `wait_strobe` closes the gate only when `wstop_bit` is 1 in that same cycle. A strobe with the bit at 0 has no effect.
- R7: `wake` opens the gate. When `wake` and a gating strobe arrive in the same cycle, `wake` wins.
- R8: While the gate is closed or main_run is 0, `en_f1`, `en_f8`, `en_f32` and `en_can` stay 0. The main divider counts hold and resume from where they stopped.
- R9: `en_tmr32` pulses on every 32nd sub tick, including while the gate is closed.
- R10: `en_wdt` pulses once for each sub tick, one cycle later, including while the gate is closed.
- R11: In reset and on the first cycle after reset, all enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_tick | input | 1 | One-cycle pulse per main-clock period |
| sub_tick | input | 1 | One-cycle pulse per sub-clock period |
| main_run | input | 1 | 1 while the main oscillator runs |
| wstop_bit | input | 1 | Peripheral-stop-in-wait control bit |
| wait_strobe | input | 1 | One-cycle pulse when a WAIT is executed |
| wake | input | 1 | Leave wait; opens the gate |
| can_sel | input | 3 | CAN divider select (encoding in R4) |
| en_f1 | output | 1 | Main-rate peripheral enable |
| en_f8 | output | 1 | Main/8 peripheral enable |
| en_f32 | output | 1 | Main/32 peripheral enable |
| en_adc | output | 1 | A/D enable at main rate |
| en_can | output | 1 | CAN enable at programmed ratio |
| en_tmr32 | output | 1 | Sub/32 timer enable |
| en_wdt | output | 1 | Sub-rate watchdog enable |

## Verification
The case that is hardest to reach from the ports is a divider frozen partway through its period. Seeing it requires a known partial count, then ticks that must have no effect, then a resume whose first pulse arrives after exactly the missing number of ticks.

The bench resets, sends five main ticks, and closes the gate. It then sends main ticks that must produce nothing, together with enough sub ticks to show the timer side still running. After `wake` it counts f8 pulses tick by tick. The CAN select change is handled the same way: the select is switched partway through a period, and the bench counts the ticks to the next pulse.

// File: rtl/pclk_pkg.sv
package pclk_pkg;
   localparam int SEL_W = 3;

   function automatic int cnt_width(input int div);
      return (div <= 2) ? 1 : $clog2(div);
   endfunction

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/pre_div.sv
module pre_div
   import pclk_pkg::*;
#(
   parameter int DIV = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   output logic en
);
   localparam int CW = cnt_width(DIV);

   if (!is_pow2(DIV)) begin : g_bad_div
      $error("pre_div: DIV must be a power of two");
   end

   logic en_q;

   if (DIV == 1) begin : g_pass
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) en_q <= 1'b0;
         else        en_q <= tick;
      end
   end else begin : g_cnt
      localparam logic [CW-1:0] TC = CW'(DIV - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q <= '0;
            en_q  <= 1'b0;
         end else begin
            en_q <= tick && (cnt_q == TC);
            if (tick) cnt_q <= (cnt_q == TC) ? '0 : cnt_q + 1'b1;
         end
      end

      // R8
      cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !tick |=> $stable(cnt_q));
   end

   assign en = en_q;
endmodule

// File: rtl/can_div.sv
module can_div
   import pclk_pkg::*;
#(
   parameter int MAX_LOG = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [SEL_W-1:0] sel,
   output logic             en
);
   localparam int LW = $clog2(MAX_LOG + 1);

   if (MAX_LOG < 1 || MAX_LOG >= (1 << SEL_W)) begin : g_bad_log
      $error("can_div: MAX_LOG out of range for select width");
   end

   logic [LW-1:0]      log_q;
   logic [MAX_LOG-1:0] cnt_q;
   logic [MAX_LOG:0]   span;
   logic [MAX_LOG-1:0] tc;
   logic [LW-1:0]      sel_clamp;
   logic               at_tc;
   logic               en_q;

   always_comb begin
      span      = (MAX_LOG + 1)'(1) << log_q;
      tc        = MAX_LOG'(span - 1'b1);
      at_tc     = (cnt_q == tc);
      sel_clamp = (int'(sel) > MAX_LOG) ? LW'(MAX_LOG) : LW'(sel);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         log_q <= '0;
         cnt_q <= '0;
         en_q  <= 1'b0;
      end else begin
         en_q <= tick && at_tc;
         if (tick) begin
            if (at_tc) begin
               cnt_q <= '0;
               log_q <= sel_clamp;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   // R5
   ratio_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(log_q) |-> en_q);
   // R8
   can_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(cnt_q));

   assign en = en_q;
endmodule

// File: rtl/wait_gate.sv
module wait_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic wstop_bit,
   input  logic wait_strobe,
   input  logic wake,
   output logic gated
);
   logic gated_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        gated_q <= 1'b0;
      else if (wake)                     gated_q <= 1'b0;
      else if (wait_strobe && wstop_bit) gated_q <= 1'b1;
   end

   // R6
   gate_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wait_strobe && wstop_bit && !wake) |=> gated_q);
   // R6
   gate_noset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!gated_q && !(wait_strobe && wstop_bit)) |=> !gated_q);
   // R7
   wake_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wake |=> !gated_q);

   assign gated = gated_q;
endmodule

// File: rtl/periph_clk_prescaler.sv
module periph_clk_prescaler
   import pclk_pkg::*;
#(
   parameter int MID_DIV  = 8,
   parameter int SLOW_DIV = 32,
   parameter int SUB_DIV  = 32,
   parameter int CAN_LOG  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             main_tick,
   input  logic             sub_tick,
   input  logic             main_run,
   input  logic             wstop_bit,
   input  logic             wait_strobe,
   input  logic             wake,
   input  logic [SEL_W-1:0] can_sel,
   output logic             en_f1,
   output logic             en_f8,
   output logic             en_f32,
   output logic             en_adc,
   output logic             en_can,
   output logic             en_tmr32,
   output logic             en_wdt
);
   if (SLOW_DIV <= MID_DIV) begin : g_bad_order
      $error("periph_clk_prescaler: SLOW_DIV must exceed MID_DIV");
   end

   logic gated;
   logic main_ok;
   logic main_act;
   logic adc_q;
   logic wdt_q;

   assign main_ok  = main_tick && main_run;
   assign main_act = main_ok && !gated;

   wait_gate u_gate (
      .clk(clk), .rst_n(rst_n), .wstop_bit(wstop_bit),
      .wait_strobe(wait_strobe), .wake(wake), .gated(gated));

   pre_div #(.DIV(1)) u_f1 (
      .clk(clk), .rst_n(rst_n), .tick(main_act), .en(en_f1));
   pre_div #(.DIV(MID_DIV)) u_f8 (
      .clk(clk), .rst_n(rst_n), .tick(main_act), .en(en_f8));
   pre_div #(.DIV(SLOW_DIV)) u_f32 (
      .clk(clk), .rst_n(rst_n), .tick(main_act), .en(en_f32));
   can_div #(.MAX_LOG(CAN_LOG)) u_can (
      .clk(clk), .rst_n(rst_n), .tick(main_act), .sel(can_sel), .en(en_can));
   pre_div #(.DIV(SUB_DIV)) u_tmr (
      .clk(clk), .rst_n(rst_n), .tick(sub_tick), .en(en_tmr32));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         adc_q <= 1'b0;
         wdt_q <= 1'b0;
      end else begin
         adc_q <= main_ok;
         wdt_q <= sub_tick;
      end
   end

   assign en_adc = adc_q;
   assign en_wdt = wdt_q;

   // R2
   f8_in_f1_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en_f8 |-> en_f1);
   // R2
   f32_in_f8_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en_f32 |-> en_f8);
   // R3
   f1_in_adc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en_f1 |-> en_adc);
   // R4
   can_in_f1_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en_can |-> en_f1);
   // R9
   tmr_in_wdt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en_tmr32 |-> en_wdt);
   // R8
   gated_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gated && $past(gated)) |-> !en_f1);
endmodule

// File: tb/tb_periph_clk_prescaler.sv
module tb_periph_clk_prescaler;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic main_tick = 1'b0, sub_tick = 1'b0, main_run = 1'b1;
   logic wstop_bit = 1'b0, wait_strobe = 1'b0, wake = 1'b0;
   logic [2:0] can_sel = 3'd0;
   logic en_f1, en_f8, en_f32, en_adc, en_can, en_tmr32, en_wdt;

   int total = 0;
   int bad = 0;
   int c_f1 = 0, c_f8 = 0, c_f32 = 0, c_adc = 0, c_can = 0, c_tmr = 0, c_wdt = 0;
   int s_f1, s_f8, s_f32, s_adc, s_can, s_tmr, s_wdt;

   always #5 clk = ~clk;

   periph_clk_prescaler dut (
      .clk(clk), .rst_n(rst_n), .main_tick(main_tick), .sub_tick(sub_tick),
      .main_run(main_run), .wstop_bit(wstop_bit), .wait_strobe(wait_strobe),
      .wake(wake), .can_sel(can_sel), .en_f1(en_f1), .en_f8(en_f8),
      .en_f32(en_f32), .en_adc(en_adc), .en_can(en_can),
      .en_tmr32(en_tmr32), .en_wdt(en_wdt));

   always @(negedge clk) begin
      c_f1  <= c_f1  + int'(en_f1);
      c_f8  <= c_f8  + int'(en_f8);
      c_f32 <= c_f32 + int'(en_f32);
      c_adc <= c_adc + int'(en_adc);
      c_can <= c_can + int'(en_can);
      c_tmr <= c_tmr + int'(en_tmr32);
      c_wdt <= c_wdt + int'(en_wdt);
   end

   typedef struct packed {
      logic [2:0] sel;
      logic       run;
      logic       gate;
      logic [7:0] n;
      logic [7:0] f1, f8, f32, adc, can;
   } vec_t;

   // sel, run, gate, ticks, f1, f8, f32, adc, can
   localparam vec_t TBL [8] = '{
      '{3'd0, 1'b1, 1'b0, 8'd40, 8'd40, 8'd5, 8'd1, 8'd40, 8'd40},
      '{3'd1, 1'b1, 1'b0, 8'd40, 8'd40, 8'd5, 8'd1, 8'd40, 8'd20},
      '{3'd2, 1'b1, 1'b0, 8'd33, 8'd33, 8'd4, 8'd1, 8'd33, 8'd9},
      '{3'd3, 1'b1, 1'b0, 8'd64, 8'd64, 8'd8, 8'd2, 8'd64, 8'd8},
      '{3'd4, 1'b1, 1'b0, 8'd64, 8'd64, 8'd8, 8'd2, 8'd64, 8'd4},
      '{3'd7, 1'b1, 1'b0, 8'd64, 8'd64, 8'd8, 8'd2, 8'd64, 8'd4},
      '{3'd3, 1'b1, 1'b1, 8'd64, 8'd0,  8'd0, 8'd0, 8'd64, 8'd0},
      '{3'd2, 1'b0, 1'b0, 8'd16, 8'd0,  8'd0, 8'd0, 8'd0,  8'd0}
   };

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic snap();
      @(negedge clk);
      s_f1 = c_f1; s_f8 = c_f8; s_f32 = c_f32; s_adc = c_adc;
      s_can = c_can; s_tmr = c_tmr; s_wdt = c_wdt;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      main_tick = 1'b0; sub_tick = 1'b0; wstop_bit = 1'b0;
      wait_strobe = 1'b0; wake = 1'b0; main_run = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic mticks(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk) main_tick = 1'b1;
         @(negedge clk) main_tick = 1'b0;
      end
      repeat (2) @(negedge clk);
   endtask

   task automatic sticks(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk) sub_tick = 1'b1;
         @(negedge clk) sub_tick = 1'b0;
      end
      repeat (2) @(negedge clk);
   endtask

   task automatic strobe(input logic stop, input logic wk);
      @(negedge clk);
      wstop_bit = stop; wait_strobe = 1'b1; wake = wk;
      @(negedge clk);
      wait_strobe = 1'b0; wake = 1'b0;
      @(negedge clk);
   endtask

   task automatic pulse_wake();
      @(negedge clk) wake = 1'b1;
      @(negedge clk) wake = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      // R11 reset state
      repeat (2) @(negedge clk);
      check("R11 reset f1", int'(en_f1), 0);
      check("R11 reset wdt", int'(en_wdt), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R11 after reset all", int'({en_f1, en_f8, en_f32, en_adc, en_can, en_tmr32, en_wdt}), 0);

      // table walk: R1 R2 R3 R4 R6 R8
      foreach (TBL[i]) begin
         can_sel = TBL[i].sel;
         do_reset();
         main_run = TBL[i].run;
         if (TBL[i].gate) strobe(1'b1, 1'b0);
         snap();
         mticks(int'(TBL[i].n));
         check($sformatf("R1 row%0d f1", i), c_f1 - s_f1, int'(TBL[i].f1));
         check($sformatf("R2 row%0d f8", i), c_f8 - s_f8, int'(TBL[i].f8));
         check($sformatf("R2 row%0d f32", i), c_f32 - s_f32, int'(TBL[i].f32));
         check($sformatf("R3 row%0d adc", i), c_adc - s_adc, int'(TBL[i].adc));
         check($sformatf("R4 row%0d can", i), c_can - s_can, int'(TBL[i].can));
      end

      // R1 latency: pulse one cycle after the tick
      do_reset();
      @(negedge clk) main_tick = 1'b1;
      @(negedge clk) main_tick = 1'b0;
      check("R1 latency high", int'(en_f1), 1);
      @(negedge clk);
      check("R1 latency low", int'(en_f1), 0);

      // R5 select change mid-period
      can_sel = 3'd2;
      do_reset();
      mticks(3);
      can_sel = 3'd0;
      snap();
      mticks(1);
      check("R5 old ratio still held", c_can - s_can, 0);
      mticks(1);
      check("R5 terminal count at old ratio", c_can - s_can, 1);
      mticks(2);
      check("R5 new ratio after tc", c_can - s_can, 3);

      // R8 hold while gated, R9 R10 keep running
      can_sel = 3'd0;
      do_reset();
      mticks(5);
      strobe(1'b1, 1'b0);
      snap();
      mticks(10);
      check("R8 no f1 while gated", c_f1 - s_f1, 0);
      check("R8 no can while gated", c_can - s_can, 0);
      check("R3 adc while gated", c_adc - s_adc, 10);
      sticks(64);
      check("R9 tmr32 during wait", c_tmr - s_tmr, 2);
      check("R10 wdt during wait", c_wdt - s_wdt, 64);
      pulse_wake();
      snap();
      mticks(2);
      check("R8 f8 not early after resume", c_f8 - s_f8, 0);
      mticks(1);
      check("R8 f8 resumes from held count", c_f8 - s_f8, 1);

      // R6 strobe with stop bit 0 does nothing
      do_reset();
      strobe(1'b0, 1'b0);
      snap();
      mticks(8);
      check("R6 stop bit 0 no gate f8", c_f8 - s_f8, 1);

      // R7 wake wins over simultaneous strobe
      do_reset();
      strobe(1'b1, 1'b1);
      snap();
      mticks(4);
      check("R7 wake priority f1", c_f1 - s_f1, 4);

      // R7 wake reopens gate
      strobe(1'b1, 1'b0);
      pulse_wake();
      snap();
      mticks(3);
      check("R7 wake reopens f1", c_f1 - s_f1, 3);

      // R9 R10 sub path alone
      do_reset();
      snap();
      sticks(40);
      check("R9 tmr32 count", c_tmr - s_tmr, 1);
      check("R10 wdt count", c_wdt - s_wdt, 40);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule